// File: doc/BRIEF.md
# Dual-CPU Interrupt Level Aggregator

This block gathers system interrupt requests on behalf of two processors and turns them into an encoded priority level for each one. Five sources exist: a reset request, vertical blank, horizontal blank, a command request and a PWM request. The reset request is common to both processors. The others are held per processor. Trigger pulses come from timers or register writes. A per-processor enable register decides, at the instant a pulse arrives, whether that processor records it.

Each processor sees a level on its IRL output. The level is twice the index of the highest pending bit. When a processor runs an acknowledge cycle, the block compares that level with the level of the processor's own internal peripheral request. It then returns either an external vector or the internal one. In the second case it also clears the internal request and records the level now being served. Software removes latched requests through a write-one-to-clear strobe.

Pending-vector positions: PWM at bit 3, command at bit 4, horizontal blank at bit 5, vertical blank at bit 6, reset at bit 7. Enable bit k guards pending bit k+3, so enable bit 0 is PWM, bit 1 is command, bit 2 is horizontal blank and bit 3 is vertical blank. The resulting levels are 6, 8, 10, 12 and 14.

Top module: `irq_level_agg`

## Requirements
- R1: After synchronous reset, all pending bits, both enable registers, both IRL outputs and both served-level outputs are zero.
- R2: A pulse on trig_i bit 7 sets the shared reset bit whatever the enable registers hold. Two clocks later both IRL outputs read 14.
- R3: A pulse on trig_i bit 3, 5 or 6 is latched for a processor only if that processor's enable bit (position minus 3) is set in the same cycle. Clearing the enable bit afterwards leaves a latched bit in place.
- R4: Processor 0's command request (level 8) is present exactly while its enable bit 1 and cmd_reg_i bit 0 are both set, and disappears when either drops.
- R5: Processor 1's command request follows the same rule using its own enable bit 1 and cmd_reg_i bit 1.
- R6: Each IRL output equals twice the index of the highest set bit among shared, private and command requests, or 0 when none is set. It is registered one clock after the requests.
- R7: On acknowledge, when the IRL level is greater than int_lvl_i, ack_vec_o is 64 plus IRL/2 and int_clr_o stays low.
- R8: Otherwise ack_vec_o equals int_vec_i and int_clr_o pulses in that cycle. From the next clock, cur_lvl_o holds the IRL level seen at acknowledge.
- R9: A clear strobe with data bit n set removes private bit n of that processor. Bit 7 removes the shared reset bit for both processors. A trigger in the same cycle wins over a clear.
- R10: A pulse on trig_i bit 4 has no effect; the command source is only level-driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 8 | Trigger pulses by pending position |
| cmd_reg_i | input | 2 | Command register, bit c for processor c |
| mask_we_i | input | 2 | Enable register write strobe per processor |
| mask_wdata_i | input | 4 | Enable register write data |
| clr_we_i | input | 2 | Clear strobe per processor |
| clr_data_i | input | 8 | Write-one-to-clear pattern |
| ack_i | input | 2 | Acknowledge cycle per processor |
| int_lvl_i | input | 2x4 | Internal peripheral level per processor |
| int_vec_i | input | 2x8 | Internal peripheral vector per processor |
| irl_o | output | 2x4 | Encoded level per processor |
| ack_vec_o | output | 2x8 | Vector returned during acknowledge |
| int_clr_o | output | 2 | Clears internal request on acknowledge |
| cur_lvl_o | output | 2x4 | Level recorded at the last internal acknowledge |

## Verification
The assertions check every cycle that a reset pulse shows as level 14 two clocks later, that a low command bit never leaves level 8 behind, and that an empty request set gives level 0. They also check that the acknowledge result, the clear pulse and the recorded level match the level comparison. Gating by enables at trigger time, the survival of latched bits after an enable is dropped, the shared clear and the precedence of a trigger over a clear depend on event history. Only the bench scenarios and its reference model can show those.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NCPU     = 2;
    localparam int PEND_W   = 8;
    localparam int MASK_W   = 4;
    localparam int MASK_OFS = 3;
    localparam int LVL_W    = $clog2(PEND_W) + 1;
    localparam int VEC_W    = 8;
    localparam int VEC_BASE = 64;

    localparam int POS_PWM = 3;
    localparam int POS_CMD = 4;
    localparam int POS_HBL = 5;
    localparam int POS_VBL = 6;
    localparam int POS_RST = 7;
    localparam int CMD_EN_BIT = POS_CMD - MASK_OFS;

    typedef logic [PEND_W-1:0] pend_t;
    typedef logic [MASK_W-1:0] mask_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [VEC_W-1:0]  vec_t;

    typedef struct packed {
        logic ext_wins;
        vec_t vec;
    } ack_res_t;

    // enable bit k guards pending position k+MASK_OFS
    function automatic pend_t enable_positions(mask_t m);
        return pend_t'(m) << MASK_OFS;
    endfunction

    // twice the index of the highest set bit, 0 when empty
    function automatic lvl_t top_level(pend_t p);
        lvl_t l = '0;
        for (int i = 0; i < PEND_W; i++) begin
            if (p[i]) l = lvl_t'(2 * i);
        end
        return l;
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_agg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pend_t trig_i,
    input  logic  mask_we_i,
    input  mask_t mask_wdata_i,
    input  logic  clr_we_i,
    input  pend_t clr_data_i,
    input  logic  cmd_bit_i,
    output mask_t mask_o,
    output pend_t priv_o,
    output logic  cmd_o
);
    localparam pend_t CMD_ONEHOT = pend_t'(1) << POS_CMD;

    mask_t mask_q;
    pend_t priv_q;
    pend_t set_v;
    pend_t clr_v;

    always_comb begin
        set_v = trig_i & enable_positions(mask_q) & ~CMD_ONEHOT;
        clr_v = clr_we_i ? clr_data_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            priv_q <= '0;
        end else begin
            priv_q <= (priv_q & ~clr_v) | set_v;
            if (mask_we_i) mask_q <= mask_wdata_i;
        end
    end

    assign mask_o = mask_q;
    assign priv_o = priv_q;
    assign cmd_o  = mask_q[CMD_EN_BIT] & cmd_bit_i;
endmodule

// File: rtl/irq_lvl_enc.sv
module irq_lvl_enc
    import irq_agg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pend_t agg_i,
    output lvl_t  irl_o
);
    lvl_t irl_q;

    always_ff @(posedge clk) begin
        if (rst) irl_q <= '0;
        else     irl_q <= top_level(agg_i);
    end

    assign irl_o = irl_q;
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ack_i,
    input  lvl_t irl_i,
    input  lvl_t int_lvl_i,
    input  vec_t int_vec_i,
    output vec_t vec_o,
    output logic int_clr_o,
    output lvl_t cur_lvl_o
);
    ack_res_t res;
    lvl_t     cur_q;

    always_comb begin
        res.ext_wins = irl_i > int_lvl_i;
        res.vec      = res.ext_wins ? vec_t'(VEC_BASE) + vec_t'(irl_i >> 1) : int_vec_i;
    end

    always_ff @(posedge clk) begin
        if (rst)                        cur_q <= '0;
        else if (ack_i && !res.ext_wins) cur_q <= irl_i;
    end

    assign vec_o     = ack_i ? res.vec : '0;
    assign int_clr_o = ack_i & ~res.ext_wins;
    assign cur_lvl_o = cur_q;
endmodule

// File: rtl/irq_level_agg.sv
module irq_level_agg
    import irq_agg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [PEND_W-1:0]          trig_i,
    input  logic [NCPU-1:0]            cmd_reg_i,
    input  logic [NCPU-1:0]            mask_we_i,
    input  logic [MASK_W-1:0]          mask_wdata_i,
    input  logic [NCPU-1:0]            clr_we_i,
    input  logic [PEND_W-1:0]          clr_data_i,
    input  logic [NCPU-1:0]            ack_i,
    input  logic [NCPU-1:0][LVL_W-1:0] int_lvl_i,
    input  logic [NCPU-1:0][VEC_W-1:0] int_vec_i,
    output logic [NCPU-1:0][LVL_W-1:0] irl_o,
    output logic [NCPU-1:0][VEC_W-1:0] ack_vec_o,
    output logic [NCPU-1:0]            int_clr_o,
    output logic [NCPU-1:0][LVL_W-1:0] cur_lvl_o
);
    logic               shared_q;
    logic               shared_clr;
    pend_t [NCPU-1:0]   priv;
    pend_t [NCPU-1:0]   agg;
    mask_t [NCPU-1:0]   mask;
    logic  [NCPU-1:0]   cmd_req;

    // shared reset request: never gated, one clear strobe drops it for all
    assign shared_clr = |(clr_we_i & {NCPU{clr_data_i[POS_RST]}});

    always_ff @(posedge clk) begin
        if (rst)                  shared_q <= 1'b0;
        else if (trig_i[POS_RST]) shared_q <= 1'b1;
        else if (shared_clr)      shared_q <= 1'b0;
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        irq_pend_bank u_bank (
            .clk          (clk),
            .rst          (rst),
            .trig_i       (trig_i),
            .mask_we_i    (mask_we_i[c]),
            .mask_wdata_i (mask_wdata_i),
            .clr_we_i     (clr_we_i[c]),
            .clr_data_i   (clr_data_i),
            .cmd_bit_i    (cmd_reg_i[c]),
            .mask_o       (mask[c]),
            .priv_o       (priv[c]),
            .cmd_o        (cmd_req[c])
        );

        assign agg[c] = priv[c]
                      | (pend_t'(shared_q)   << POS_RST)
                      | (pend_t'(cmd_req[c]) << POS_CMD);

        irq_lvl_enc u_enc (
            .clk   (clk),
            .rst   (rst),
            .agg_i (agg[c]),
            .irl_o (irl_o[c])
        );

        irq_ack_unit u_ack (
            .clk       (clk),
            .rst       (rst),
            .ack_i     (ack_i[c]),
            .irl_i     (irl_o[c]),
            .int_lvl_i (int_lvl_i[c]),
            .int_vec_i (int_vec_i[c]),
            .vec_o     (ack_vec_o[c]),
            .int_clr_o (int_clr_o[c]),
            .cur_lvl_o (cur_lvl_o[c])
        );
    end
endmodule

// File: rtl/irq_level_agg_chk.sv
module irq_level_agg_chk
    import irq_agg_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       trig_rst,
    input logic [NCPU-1:0]            cmd_reg_i,
    input logic [NCPU-1:0]            ack_i,
    input logic [NCPU-1:0][LVL_W-1:0] int_lvl_i,
    input logic [NCPU-1:0][VEC_W-1:0] int_vec_i,
    input logic [NCPU-1:0][LVL_W-1:0] irl_o,
    input logic [NCPU-1:0][VEC_W-1:0] ack_vec_o,
    input logic [NCPU-1:0]            int_clr_o,
    input logic [NCPU-1:0][LVL_W-1:0] cur_lvl_o,
    input pend_t [NCPU-1:0]           agg
);
    localparam lvl_t RST_LVL = lvl_t'(2 * POS_RST);
    localparam lvl_t CMD_LVL = lvl_t'(2 * POS_CMD);

    for (genvar c = 0; c < NCPU; c++) begin : g_chk
        p_rst_level_r2: assert property (@(posedge clk) disable iff (rst)
            trig_rst |=> ##1 (irl_o[c] == RST_LVL));

        p_cmd_gone_r4: assert property (@(posedge clk) disable iff (rst)
            $past(!cmd_reg_i[c]) |-> (irl_o[c] != CMD_LVL));

        p_empty_zero_r6: assert property (@(posedge clk) disable iff (rst)
            $past(agg[c] == '0) |-> (irl_o[c] == '0));

        p_ack_ext_r7: assert property (@(posedge clk) disable iff (rst)
            (ack_i[c] && irl_o[c] > int_lvl_i[c]) |->
            (ack_vec_o[c] == vec_t'(VEC_BASE) + vec_t'(irl_o[c] >> 1) && !int_clr_o[c]));

        p_ack_int_r8: assert property (@(posedge clk) disable iff (rst)
            (ack_i[c] && !(irl_o[c] > int_lvl_i[c])) |->
            (ack_vec_o[c] == int_vec_i[c] && int_clr_o[c]));

        p_cur_lvl_r8: assert property (@(posedge clk) disable iff (rst)
            (ack_i[c] && !(irl_o[c] > int_lvl_i[c])) |=> (cur_lvl_o[c] == $past(irl_o[c])));

        p_clr_needs_ack_r8: assert property (@(posedge clk) disable iff (rst)
            int_clr_o[c] |-> ack_i[c]);
    end
endmodule

bind irq_level_agg irq_level_agg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig_rst  (trig_i[irq_agg_pkg::POS_RST]),
    .cmd_reg_i (cmd_reg_i),
    .ack_i     (ack_i),
    .int_lvl_i (int_lvl_i),
    .int_vec_i (int_vec_i),
    .irl_o     (irl_o),
    .ack_vec_o (ack_vec_o),
    .int_clr_o (int_clr_o),
    .cur_lvl_o (cur_lvl_o),
    .agg       (agg)
);

// File: tb/irq_level_agg_tb.sv
module irq_level_agg_tb;
    logic             clk = 0;
    logic             rst = 1;
    logic [7:0]       trig_i = 0;
    logic [1:0]       cmd_reg_i = 0, mask_we_i = 0, clr_we_i = 0, ack_i = 0;
    logic [3:0]       mask_wdata_i = 0;
    logic [7:0]       clr_data_i = 0;
    logic [1:0][3:0]  int_lvl_i = 0;
    logic [1:0][7:0]  int_vec_i = 0;
    logic [1:0][3:0]  irl_o, cur_lvl_o;
    logic [1:0][7:0]  ack_vec_o;
    logic [1:0]       int_clr_o;

    int errors = 0, checks = 0;
    bit done = 0;

    // reference state
    logic       m_shared;
    logic [7:0] m_priv [2];
    logic [3:0] m_mask [2];
    logic [3:0] m_irl  [2];
    logic [3:0] m_cur  [2];

    irq_level_agg u_dut (.*);

    always #2 clk = ~clk;

    function automatic logic [3:0] ref_level(logic [7:0] p);
        for (int i = 7; i >= 0; i--) if (p[i]) return 4'(2 * i);
        return 4'd0;
    endfunction

    function automatic logic [7:0] ref_agg(int c);
        logic cmdb = m_mask[c][1] & cmd_reg_i[c];
        return m_priv[c] | {m_shared, 7'b0} | {3'b0, cmdb, 4'b0};
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_shared = 0;
        for (int c = 0; c < 2; c++) begin
            m_priv[c] = 0; m_mask[c] = 0; m_irl[c] = 0; m_cur[c] = 0;
        end
    endtask

    // called at a negedge with inputs driven; returns at the next negedge
    task automatic step();
        logic [3:0] nirl [2];
        logic       intw [2];
        #1;
        for (int c = 0; c < 2; c++) begin
            intw[c] = ack_i[c] && !(m_irl[c] > int_lvl_i[c]);
            if (ack_i[c]) begin
                if (!intw[c]) begin
                    chk("R7 vec", ack_vec_o[c], 64 + m_irl[c] / 2);
                    chk("R7 clr", int_clr_o[c], 0);
                end else begin
                    chk("R8 vec", ack_vec_o[c], int_vec_i[c]);
                    chk("R8 clr", int_clr_o[c], 1);
                end
            end
        end
        @(posedge clk);
        for (int c = 0; c < 2; c++) begin
            nirl[c] = ref_level(ref_agg(c));
            if (intw[c]) m_cur[c] = m_irl[c];
        end
        if (trig_i[7]) m_shared = 1;
        else if (|(clr_we_i & {2{clr_data_i[7]}})) m_shared = 0;
        for (int c = 0; c < 2; c++) begin
            logic [7:0] setv = trig_i & ({m_mask[c], 3'b0}) & 8'b1110_1111;
            logic [7:0] clrv = clr_we_i[c] ? clr_data_i : 8'h00;
            m_priv[c] = (m_priv[c] & ~clrv) | setv;
            if (mask_we_i[c]) m_mask[c] = mask_wdata_i;
            m_irl[c] = nirl[c];
        end
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            chk("R6 irl", irl_o[c], m_irl[c]);
            chk("R8 cur", cur_lvl_o[c], m_cur[c]);
        end
        trig_i = 0; mask_we_i = 0; clr_we_i = 0; ack_i = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_mask(int c, logic [3:0] v);
        mask_we_i[c] = 1; mask_wdata_i = v; step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1 irl0", irl_o[0], 0); chk("R1 irl1", irl_o[1], 0);
        chk("R1 cur0", cur_lvl_o[0], 0); chk("R1 cur1", cur_lvl_o[1], 0);

        // R2: shared reset ignores enables
        trig_i = 8'h80; step(); idle(1);
        chk("R2 irl0", irl_o[0], 14); chk("R2 irl1", irl_o[1], 14);
        // R9: bit 7 clear via processor 1 drops it for both
        clr_we_i[1] = 1; clr_data_i = 8'h80; step(); idle(1);
        chk("R9 irl0", irl_o[0], 0); chk("R9 irl1", irl_o[1], 0);

        // R3: PWM blocked without enable
        trig_i = 8'h08; step(); idle(1);
        chk("R3 blocked", irl_o[0], 0);
        set_mask(0, 4'b0001);
        trig_i = 8'h08; step(); idle(1);
        chk("R3 latched", irl_o[0], 6); chk("R3 other cpu", irl_o[1], 0);
        set_mask(0, 4'b0000); idle(1);
        chk("R3 kept", irl_o[0], 6);
        // R9: trigger wins over clear
        set_mask(0, 4'b0001);
        trig_i = 8'h08; clr_we_i[0] = 1; clr_data_i = 8'h08; step(); idle(1);
        chk("R9 set wins", irl_o[0], 6);
        clr_we_i[0] = 1; clr_data_i = 8'h08; step(); idle(1);
        chk("R9 private clr", irl_o[0], 0);

        // R10: trigger at command position has no effect
        set_mask(0, 4'b0010);
        trig_i = 8'h10; step(); idle(1);
        chk("R10 ignored", irl_o[0], 0);

        // R4: processor 0 command level
        cmd_reg_i = 2'b01; idle(2);
        chk("R4 on", irl_o[0], 8); chk("R4 cpu1 off", irl_o[1], 0);
        cmd_reg_i = 2'b00; idle(1);
        chk("R4 off cmd", irl_o[0], 0);
        cmd_reg_i = 2'b01; idle(1);
        set_mask(0, 4'b0000); idle(1);
        chk("R4 off mask", irl_o[0], 0);

        // R5: processor 1 command level
        set_mask(1, 4'b0010);
        cmd_reg_i = 2'b10; idle(2);
        chk("R5 on", irl_o[1], 8); chk("R5 cpu0 off", irl_o[0], 0);
        cmd_reg_i = 2'b00; idle(1);
        chk("R5 off", irl_o[1], 0);

        // R7 / R8 directed acknowledge with level 8 on processor 1
        cmd_reg_i = 2'b10; idle(2);
        ack_i[1] = 1; int_lvl_i[1] = 4'd3; int_vec_i[1] = 8'h55; step();
        ack_i[1] = 1; int_lvl_i[1] = 4'd8; int_vec_i[1] = 8'hA7; step();
        chk("R8 cur dir", cur_lvl_o[1], 8);
        cmd_reg_i = 2'b00;

        // constrained random
        for (int it = 0; it < 600; it++) begin
            logic [7:0] t = 8'($urandom);
            if ($urandom % 4 != 0) t = 0;
            if ($urandom % 6 != 0) t[7] = 0;
            trig_i = t;
            cmd_reg_i = 2'($urandom);
            mask_we_i = ($urandom % 5 == 0) ? 2'($urandom) : 2'b00;
            mask_wdata_i = 4'($urandom);
            clr_we_i = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
            clr_data_i = 8'($urandom);
            ack_i = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
            int_lvl_i = 8'($urandom);
            int_vec_i = 16'($urandom);
            step();
        end

        // R1: reset mid-run
        trig_i = 8'h80; step();
        rst = 1; @(negedge clk); @(negedge clk); rst = 0; model_reset();
        chk("R1 re-irl0", irl_o[0], 0); chk("R1 re-cur1", cur_lvl_o[1], 0);
        cmd_reg_i = 2'b11; idle(2);
        chk("R1 mask cleared", irl_o[0], 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule